// File: doc/BRIEF.md
# Dataflow Operand Join Unit

This block gathers the three operands of a dataflow node before the node may run. A caller first arms a node slot, picking one of two join disciplines. Operand messages then arrive. Each names a slot, an input position and a data word. The unit stores the word in that slot's operand storage, then updates the slot's join state. The arrival that completes the set produces a fire event carrying the slot index and all three operand values. Any other accepted arrival produces a "no fire" pulse, which tells the caller to resume whatever pending work it has.

There are two join disciplines. In presence-bitmask mode each input position owns a flag, so repeated arrivals at the same position are harmless. In down-counter mode every arrival counts, including repeats. In both modes a slot fires at most once per arming and is disarmed afterwards. An arrival at a slot that is not armed, or at an undefined position, raises a one-cycle error pulse and changes nothing.

Top module: `dfjoin_unit`

## Requirements
- R1: After reset, all outputs are low and every node slot is unarmed, so an arrival at any slot raises `err_o`.
- R2: An arrival at an unarmed slot, or with position code 3, raises `err_o` for one cycle, one cycle after the arrival. It writes no operand, changes no join state, and produces neither `fire_valid_o` nor `nofire_o`.
- R3: Arming with `arm_mode_i`=0 (bitmask mode) loads flags 3'b111. An accepted arrival at position p (0..2) clears flag bit p. The slot completes on the arrival that leaves all flags clear.
- R4: In bitmask mode, a repeated arrival at a position whose flag is already clear leaves the flags unchanged and yields `nofire_o`. It still overwrites the stored operand.
- R5: Arming with `arm_mode_i`=1 (counter mode) loads a count of 3. Every accepted arrival decrements the count, including repeats at the same position. The slot completes when the count reaches zero.
- R6: On completion, `fire_valid_o` pulses for one cycle, one cycle after the arrival. With it, `fire_node_o` gives the slot, and `fire_ops_o` holds operand k in bits [k*DATA_W +: DATA_W]. The completing arrival's own data is included.
- R7: An accepted arrival that does not complete its slot pulses `nofire_o` for one cycle, one cycle after the arrival.
- R8: A slot that has fired is disarmed, so it fires at most once per arming. Further arrivals at it raise `err_o` until it is armed again.
- R9: Re-arming a slot at any time restarts its join state in the newly chosen mode. Stored operand data is kept.
- R10: When an arm and an arrival target the same slot in the same cycle, the arrival is judged against the state before the arm. The arm's reload then sets the state that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_valid_i | input | 1 | Arm command strobe |
| arm_node_i | input | IDX_W | Slot to arm |
| arm_mode_i | input | 1 | 0 = bitmask join, 1 = counter join |
| msg_valid_i | input | 1 | Operand arrival strobe |
| msg_node_i | input | IDX_W | Target slot of the arrival |
| msg_pos_i | input | 2 | Input position 0..2 (3 is invalid) |
| msg_data_i | input | DATA_W | Operand value |
| fire_valid_o | output | 1 | Node complete, one-cycle pulse |
| fire_node_o | output | IDX_W | Slot that fired |
| fire_ops_o | output | 3*DATA_W | Operand values, position k at [k*DATA_W +: DATA_W] |
| nofire_o | output | 1 | Accepted arrival, slot still incomplete |
| err_o | output | 1 | Arrival rejected |

## Verification
The bitmask discipline is tried in three ways: with positions arriving in scrambled order, with a repeated position before the last one, and across a re-arm in mid-collection. Together these separate the flag semantics from simple counting. The counter discipline is fed three arrivals at one position, so it fires where the bitmask would not. The invalid position code is sent into a counting slot, which would fire early if that arrival had decremented it. Arm and arrival collisions on one slot, in both armed and unarmed states, show the old-state-then-reload order. A long seeded random mix of arms, modes, positions and slots is checked against a behavioural model of the slots.

// File: rtl/dfjoin_pkg.sv
package dfjoin_pkg;
  localparam int unsigned OPS = 3;
  localparam int unsigned POS_W = 2;

  typedef enum logic {
    JOIN_MASK  = 1'b0,
    JOIN_COUNT = 1'b1
  } join_mode_e;
endpackage

// File: rtl/dfjoin_slot.sv
module dfjoin_slot
  import dfjoin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  join_mode_e       arm_mode_i,
  input  logic             hit_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             armed_o,
  output logic             complete_o
);
  logic [OPS-1:0] st_q, st_next;
  join_mode_e     mode_q;
  logic           armed_q;

  always_comb begin
    if (mode_q == JOIN_COUNT) st_next = st_q - OPS'(1);
    else                      st_next = st_q & ~(OPS'(1) << pos_i);
  end

  assign armed_o    = armed_q;
  assign complete_o = hit_i && armed_q && (st_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= JOIN_MASK;
      st_q    <= '0;
    end else if (arm_i) begin
      // reload wins over a same-cycle arrival
      armed_q <= 1'b1;
      mode_q  <= arm_mode_i;
      st_q    <= (arm_mode_i == JOIN_COUNT) ? OPS'(OPS) : '1;
    end else if (hit_i && armed_q) begin
      st_q <= st_next;
      if (st_next == '0) armed_q <= 1'b0;
    end
  end

  a_r3_armed_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> st_q != '0);

  a_r8_disarm_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o && !arm_i |=> !armed_o);

  a_r4_dup_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && armed_q && mode_q == JOIN_MASK && pos_i != 2'd3 &&
    !st_q[pos_i] && !arm_i |=> $stable(st_q) && armed_o);

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && armed_q && mode_q == JOIN_COUNT && !arm_i |=>
    st_q == $past(st_q) - OPS'(1));
endmodule

// File: rtl/dfjoin_store.sv
module dfjoin_store
  import dfjoin_pkg::*;
#(
  parameter int unsigned NODES  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NODES),
  localparam int unsigned ROW_W = OPS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_node_i,
  input  logic [POS_W-1:0]  wr_pos_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_node_i,
  output logic [ROW_W-1:0]  rd_ops_o
);
  logic [ROW_W-1:0] mem_q [NODES];

  // read with bypass of the write in flight, so the completing operand is seen
  always_comb begin
    rd_ops_o = mem_q[rd_node_i];
    if (wr_en_i && wr_node_i == rd_node_i)
      rd_ops_o[int'(wr_pos_i)*DATA_W +: DATA_W] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NODES); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_node_i][int'(wr_pos_i)*DATA_W +: DATA_W] <= wr_data_i;
    end
  end

  a_r2_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_pos_i < POS_W'(OPS));
endmodule

// File: rtl/dfjoin_unit.sv
module dfjoin_unit
  import dfjoin_pkg::*;
#(
  parameter int unsigned NODES  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NODES),
  localparam int unsigned ROW_W = OPS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_valid_i,
  input  logic [IDX_W-1:0]  arm_node_i,
  input  logic              arm_mode_i,
  input  logic              msg_valid_i,
  input  logic [IDX_W-1:0]  msg_node_i,
  input  logic [1:0]        msg_pos_i,
  input  logic [DATA_W-1:0] msg_data_i,
  output logic              fire_valid_o,
  output logic [IDX_W-1:0]  fire_node_o,
  output logic [ROW_W-1:0]  fire_ops_o,
  output logic              nofire_o,
  output logic              err_o
);
  logic [NODES-1:0] armed, complete;
  logic             pos_ok, accept, complete_any;
  logic [ROW_W-1:0] rd_ops;

  assign pos_ok = msg_pos_i != 2'd3;

  for (genvar g = 0; g < int'(NODES); g++) begin : g_slot
    dfjoin_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arm_i     (arm_valid_i && arm_node_i == IDX_W'(g)),
      .arm_mode_i(join_mode_e'(arm_mode_i)),
      .hit_i     (msg_valid_i && pos_ok && msg_node_i == IDX_W'(g)),
      .pos_i     (msg_pos_i),
      .armed_o   (armed[g]),
      .complete_o(complete[g])
    );
  end

  assign accept       = msg_valid_i && pos_ok && armed[msg_node_i];
  assign complete_any = |complete;

  dfjoin_store #(.NODES(NODES), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (accept),
    .wr_node_i(msg_node_i),
    .wr_pos_i (msg_pos_i),
    .wr_data_i(msg_data_i),
    .rd_node_i(msg_node_i),
    .rd_ops_o (rd_ops)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_valid_o <= 1'b0;
      fire_node_o  <= '0;
      fire_ops_o   <= '0;
      nofire_o     <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      fire_valid_o <= complete_any;
      nofire_o     <= accept && !complete_any;
      err_o        <= msg_valid_i && !accept;
      if (complete_any) begin
        fire_node_o <= msg_node_i;
        fire_ops_o  <= rd_ops;
      end
    end
  end

  a_r8_single_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(complete));

  a_r7_fire_nofire_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_valid_o && nofire_o));

  a_r2_err_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !fire_valid_o && !nofire_o);

  a_r2_bad_pos_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !pos_ok |=> err_o);

  a_r6_fire_from_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_valid_o |-> $past(msg_valid_i) && fire_node_o == $past(msg_node_i));
endmodule

// File: tb/dfjoin_unit_test.sv
`timescale 1ns/1ps
module dfjoin_unit_test;
  localparam int NODES = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm_valid = 1'b0;
  logic [2:0]    arm_node = '0;
  logic          arm_mode = 1'b0;
  logic          msg_valid = 1'b0;
  logic [2:0]    msg_node = '0;
  logic [1:0]    msg_pos = '0;
  logic [DW-1:0] msg_data = '0;
  logic          fire_valid, nofire, err;
  logic [2:0]    fire_node;
  logic [3*DW-1:0] fire_ops;

  int checks = 0;
  int fails = 0;

  // behavioural slot model
  logic          m_armed [NODES];
  logic          m_mode  [NODES];
  logic [2:0]    m_st    [NODES];
  logic [DW-1:0] m_ops   [NODES][3];

  always #4 clk = ~clk;

  dfjoin_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .arm_valid_i(arm_valid), .arm_node_i(arm_node), .arm_mode_i(arm_mode),
    .msg_valid_i(msg_valid), .msg_node_i(msg_node), .msg_pos_i(msg_pos),
    .msg_data_i(msg_data),
    .fire_valid_o(fire_valid), .fire_node_o(fire_node), .fire_ops_o(fire_ops),
    .nofire_o(nofire), .err_o(err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [3*DW-1:0] got, input logic [3*DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model it, check registered outputs next negedge
  task automatic step(input logic av, input logic [2:0] an, input logic am,
                      input logic mv, input logic [2:0] mn, input logic [1:0] mp,
                      input logic [DW-1:0] md, input string tag);
    logic acc, efire, enof, eerr;
    logic [2:0] nst;
    logic [3*DW-1:0] eops;
    acc = mv && mp != 2'd3 && m_armed[mn];
    efire = 1'b0; enof = 1'b0; eerr = mv && !acc; eops = '0;
    if (acc) begin
      m_ops[mn][mp] = md;
      nst = m_mode[mn] ? m_st[mn] - 3'd1 : m_st[mn] & ~(3'b001 << mp);
      m_st[mn] = nst;
      if (nst == 3'd0) begin
        efire = 1'b1; m_armed[mn] = 1'b0;
        eops = {m_ops[mn][2], m_ops[mn][1], m_ops[mn][0]};
      end else enof = 1'b1;
    end
    if (av) begin
      m_armed[an] = 1'b1; m_mode[an] = am; m_st[an] = am ? 3'd3 : 3'b111;
    end
    arm_valid = av; arm_node = an; arm_mode = am;
    msg_valid = mv; msg_node = mn; msg_pos = mp; msg_data = md;
    @(posedge clk);
    @(negedge clk);
    arm_valid = 1'b0; msg_valid = 1'b0;
    chk({tag, "/R6"}, "fire_valid", 96'(fire_valid), 96'(efire));
    chk({tag, "/R7"}, "nofire", 96'(nofire), 96'(enof));
    chk({tag, "/R2"}, "err", 96'(err), 96'(eerr));
    if (efire) begin
      chk({tag, "/R6"}, "fire_node", 96'(fire_node), 96'(mn));
      chk({tag, "/R6"}, "fire_ops", fire_ops, eops);
    end
  endtask

  task automatic arrive(input logic [2:0] n, input logic [1:0] p,
                        input logic [DW-1:0] d, input string tag);
    step(1'b0, 3'd0, 1'b0, 1'b1, n, p, d, tag);
  endtask

  task automatic arm(input logic [2:0] n, input logic m, input string tag);
    step(1'b1, n, m, 1'b0, 3'd0, 2'd0, '0, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NODES; i++) begin
      m_armed[i] = 1'b0; m_mode[i] = 1'b0; m_st[i] = '0;
      for (int k = 0; k < 3; k++) m_ops[i][k] = '0;
    end
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1", "reset fire_valid", 96'(fire_valid), 96'(0));
    chk("R1", "reset nofire", 96'(nofire), 96'(0));
    chk("R1", "reset err", 96'(err), 96'(0));
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NODES; i++) arrive(3'(i), 2'd0, 32'hdead_0000 + i, "R1");

    // R3: scrambled positions in bitmask mode
    arm(3'd1, 1'b0, "R3");
    arrive(3'd1, 2'd2, 32'h2222_0001, "R3");
    arrive(3'd1, 2'd0, 32'h0000_0001, "R3");
    arrive(3'd1, 2'd1, 32'h1111_0001, "R3");

    // R4: repeated position rewrites data without advancing
    arm(3'd2, 1'b0, "R4");
    arrive(3'd2, 2'd0, 32'haaaa_aaaa, "R4");
    arrive(3'd2, 2'd0, 32'hbbbb_bbbb, "R4");
    arrive(3'd2, 2'd1, 32'h1234_5678, "R4");
    arrive(3'd2, 2'd2, 32'h8765_4321, "R4");

    // R5: counter mode counts repeats
    arm(3'd3, 1'b1, "R5");
    arrive(3'd3, 2'd1, 32'h0101_0101, "R5");
    arrive(3'd3, 2'd1, 32'h0202_0202, "R5");
    arrive(3'd3, 2'd1, 32'h0303_0303, "R5");
    // R8: no second fire after completion
    arrive(3'd3, 2'd0, 32'h0404_0404, "R8");
    arrive(1'b0 ? 3'd0 : 3'd1, 2'd0, 32'h0505_0505, "R8");

    // R2: invalid position must not decrement a counter
    arm(3'd4, 1'b1, "R2");
    arrive(3'd4, 2'd3, 32'hffff_ffff, "R2");
    arrive(3'd4, 2'd0, 32'h4000_0000, "R2");
    arrive(3'd4, 2'd1, 32'h4000_0001, "R2");
    arrive(3'd4, 2'd2, 32'h4000_0002, "R2");

    // R9: re-arm mid-collection switches to counter
    arm(3'd5, 1'b0, "R9");
    arrive(3'd5, 2'd0, 32'h5000_0000, "R9");
    arrive(3'd5, 2'd1, 32'h5000_0001, "R9");
    arm(3'd5, 1'b1, "R9");
    arrive(3'd5, 2'd2, 32'h5000_0002, "R9");
    arrive(3'd5, 2'd2, 32'h5000_0003, "R9");
    arrive(3'd5, 2'd2, 32'h5000_0004, "R9");

    // R10: arm and arrival together on one slot
    arm(3'd6, 1'b0, "R10");
    step(1'b1, 3'd6, 1'b0, 1'b1, 3'd6, 2'd0, 32'h6000_0000, "R10");
    arrive(3'd6, 2'd1, 32'h6000_0001, "R10");
    arrive(3'd6, 2'd2, 32'h6000_0002, "R10");
    arrive(3'd6, 2'd0, 32'h6000_0003, "R10");
    step(1'b1, 3'd7, 1'b1, 1'b1, 3'd7, 2'd1, 32'h7000_0000, "R10");
    arrive(3'd7, 2'd1, 32'h7000_0001, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic av, mv;
      av = ($urandom % 4) == 0;
      mv = ($urandom % 4) != 0;
      step(av, 3'($urandom), 1'($urandom), mv, 3'($urandom),
           2'(($urandom % 8) == 0 ? 3 : $urandom % 3), $urandom, "rand");
    end
    step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 2'd0, '0, "idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule